// File: doc/BRIEF.md
# Two-Level Interrupt Status Aggregator with Receive Coalescing

This block gathers single-cycle event pulses from on-chip sources into two status registers and drives one interrupt line towards the host. The primary register holds general events such as firmware ready, wake-up, radio-disable switch change and firmware fault. The secondary register holds per-channel DMA completion and error events. Three primary bits are not stored at all: they are live summaries of groups of secondary bits, so the host reads the primary register first and goes to the secondary register only when a summary bit is set. Every stored status bit is acknowledged by writing a one to it.

An enable mask selects which primary bits may raise the interrupt line. The receive summary is the one coalesced source: once it is pending, the line waits for a programmable window, counted in 32-microsecond units of an external one-microsecond tick, so that several receive completions are reported by one interrupt. A high-priority receive event in the secondary register skips that wait. Writing a zero window turns coalescing off. The host reaches the four registers through a plain word-wide register port; reads have no side effects, and a write takes effect at the next clock edge.

Top module: `irq_cascade_agg`

## Requirements
- R1: After reset the primary status, secondary status, enable mask and coalescing window all read 0 and `host_irq` is low.
- R2: A pulse on `prim_evt[i]` sets stored primary bit i at the next edge; a register write to address 0 clears each bit whose write-data bit is 1 and leaves bits written 0 unchanged. Bits 31, 29 and 27 are not stored: events and writes at those positions have no effect on them.
- R3: When an event and a write-one acknowledge hit the same status bit in the same cycle, the bit reads 1 afterwards.
- R4: All 32 bits of the secondary status (address 2) are set by `dma_evt` and cleared by writing ones to address 2, with the same rules as R2.
- R5: Primary bit 31 reads the OR of secondary bits 30, 17 and 16; primary bit 29 reads secondary bit 31; primary bit 27 reads the OR of secondary bits 1 and 0.
- R6: One cycle after the registers change, `host_irq` is high whenever any primary bit other than 31 is set together with its enable bit (address 1, read/write).
- R7: With a nonzero window P (address 3, low 8 bits, upper bits read 0), an enabled receive summary raises `host_irq` one cycle after the P*32-th `us_tick` seen while it is pending, and keeps it raised until the summary clears; clearing restarts the count.
- R8: With a window of 0, an enabled receive summary raises `host_irq` one cycle after it becomes set.
- R9: Secondary bit 30 with enable bit 31 raises `host_irq` one cycle after it is set, whatever the window.
- R10: Register addresses: 0 primary status, 1 enable mask, 2 secondary status, 3 coalescing window; `reg_rdata` shows the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| prim_evt | input | 32 | Primary event pulses |
| dma_evt | input | 32 | Secondary (DMA channel) event pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data (ones acknowledge in status registers) |
| reg_rdata | output | 32 | Read data of the selected register |
| host_irq | output | 1 | Interrupt line to the host |

## Verification
A stuck or wrongly cleared status bit shows at the read port in the very next cycle, and on `host_irq` one cycle later when enabled. A summary bit wired to the wrong secondary group appears as a mismatch at address 0 as soon as a single DMA event lands. A coalescing counter that is off by one or fails to restart is visible only as `host_irq` rising one tick early or late, so the window is probed at its exact boundary after each acknowledge.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_PRIM = 2'd0,
    RA_MASK = 2'd1,
    RA_SEC  = 2'd2,
    RA_COAL = 2'd3
  } reg_addr_e;

  // primary positions
  localparam int P_RXSUM = 31;
  localparam int P_HWERR = 29;
  localparam int P_TXSUM = 27;
  // secondary positions
  localparam int S_ERR   = 31;
  localparam int S_HIPRI = 30;
  localparam int S_RX1   = 17;
  localparam int S_RX0   = 16;
  localparam int S_TX1   = 1;
  localparam int S_TX0   = 0;

  localparam int UNIT_LOG2 = 5;  // 32 ticks per window unit

  localparam logic [REG_W-1:0] PRIM_SUM_MASK =
    (REG_W'(1) << P_RXSUM) | (REG_W'(1) << P_HWERR) | (REG_W'(1) << P_TXSUM);
  localparam logic [REG_W-1:0] COAL_MASK = REG_W'(1) << P_RXSUM;
endpackage

// File: rtl/w1c_status_reg.sv
module w1c_status_reg #(
  parameter int W = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= ((q & ~clr_i) | set_i) & IMPL;
  end

  assign q_o = q;

  // set beats acknowledge
  assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_i & IMPL)) |=> ((q_o & $past(set_i & IMPL)) == $past(set_i & IMPL)));

  // write-one clears
  assert_ack_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((q_o & $past(clr_i & ~set_i)) == '0));

  // untouched bits hold
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q_o & ~$past(set_i | clr_i)) == ($past(q_o) & ~$past(set_i | clr_i))));
endmodule

// File: rtl/coalesce_timer.sv
module coalesce_timer #(
  parameter int PW = 8,
  parameter int UNIT_LOG2 = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          pend_i,
  input  logic [PW-1:0] period_i,
  output logic          fired_o
);
  localparam int CW = PW + UNIT_LOG2;

  logic [CW-1:0] cnt;
  logic          fired;
  logic [CW:0]   thr;
  logic [CW:0]   cnt_inc;

  assign thr     = {1'b0, period_i, {UNIT_LOG2{1'b0}}};
  assign cnt_inc = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || !pend_i) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else if (!fired && tick_i) begin
      if (cnt_inc >= thr) begin
        fired <= 1'b1;
        cnt   <= '0;
      end else begin
        cnt <= cnt_inc[CW-1:0];
      end
    end
  end

  assign fired_o = fired;

  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_i |=> !fired_o);

  assert_fired_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fired_o && pend_i) |=> fired_o);
endmodule

// File: rtl/irq_cascade_agg.sv
module irq_cascade_agg
  import irqagg_pkg::*;
#(
  parameter int PERIOD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic [REG_W-1:0]  prim_evt,
  input  logic [REG_W-1:0]  dma_evt,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              host_irq
);
  logic [REG_W-1:0]    prim_q, sec_q, en_q, prim_view;
  logic [REG_W-1:0]    prim_clr, sec_clr;
  logic [PERIOD_W-1:0] per_q;
  logic                rx_pend, fired, irq_next, irq_q;
  reg_addr_e           addr;

  assign addr     = reg_addr_e'(reg_addr);
  assign prim_clr = (reg_we && addr == RA_PRIM) ? reg_wdata : '0;
  assign sec_clr  = (reg_we && addr == RA_SEC)  ? reg_wdata : '0;

  w1c_status_reg #(.W(REG_W), .IMPL(~PRIM_SUM_MASK)) u_prim (
    .clk(clk), .rst_n(rst_n), .set_i(prim_evt), .clr_i(prim_clr), .q_o(prim_q));

  w1c_status_reg #(.W(REG_W), .IMPL('1)) u_sec (
    .clk(clk), .rst_n(rst_n), .set_i(dma_evt), .clr_i(sec_clr), .q_o(sec_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      per_q <= '0;
    end else if (reg_we) begin
      if (addr == RA_MASK) en_q  <= reg_wdata;
      if (addr == RA_COAL) per_q <= reg_wdata[PERIOD_W-1:0];
    end
  end

  // summary roll-up
  assign rx_pend = sec_q[S_RX1] | sec_q[S_RX0] | sec_q[S_HIPRI];
  always_comb begin
    prim_view          = prim_q;
    prim_view[P_RXSUM] = rx_pend;
    prim_view[P_HWERR] = sec_q[S_ERR];
    prim_view[P_TXSUM] = sec_q[S_TX1] | sec_q[S_TX0];
  end

  coalesce_timer #(.PW(PERIOD_W), .UNIT_LOG2(UNIT_LOG2)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(us_tick), .pend_i(rx_pend),
    .period_i(per_q), .fired_o(fired));

  assign irq_next = (|(prim_view & en_q & ~COAL_MASK)) |
                    (en_q[P_RXSUM] & (sec_q[S_HIPRI] |
                                      (rx_pend & ((per_q == '0) | fired))));

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_next;
  end
  assign host_irq = irq_q;

  always_comb begin
    unique case (addr)
      RA_PRIM: reg_rdata = prim_view;
      RA_MASK: reg_rdata = en_q;
      RA_SEC:  reg_rdata = sec_q;
      RA_COAL: reg_rdata = {{(REG_W-PERIOD_W){1'b0}}, per_q};
      default: reg_rdata = '0;
    endcase
  end

  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((prim_view & en_q) == '0) |=> !host_irq);

  assert_hipri_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q[S_HIPRI] && en_q[P_RXSUM]) |=> host_irq);

  assert_no_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pend && en_q[P_RXSUM] && per_q == '0) |=> host_irq);

  assert_nonrx_direct_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(prim_view & en_q & ~COAL_MASK)) |=> host_irq);
endmodule

// File: tb/irq_cascade_agg_bench.sv
module irq_cascade_agg_bench;
  localparam logic [31:0] SUM = 32'hA800_0000;

  logic clk = 1'b0, rst_n = 1'b0, us_tick = 1'b0, reg_we = 1'b0;
  logic [31:0] prim_evt = '0, dma_evt = '0, reg_wdata = '0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_rdata;
  logic        host_irq;

  int n_run = 0, n_fail = 0, cyc = 0;

  // reference state
  logic [31:0] m_prim = '0, m_sec = '0, m_en = '0;
  logic [7:0]  m_per = '0;
  int          m_cnt = 0;
  logic        m_fired = 1'b0, m_irq = 1'b0;

  always #4 clk = ~clk;

  irq_cascade_agg u_irq_cascade_agg (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .prim_evt(prim_evt),
    .dma_evt(dma_evt), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_irq(host_irq));

  function automatic logic [31:0] view(logic [31:0] p, logic [31:0] s);
    logic [31:0] v = p & ~SUM;
    v[31] = s[30] | s[17] | s[16];
    v[29] = s[31];
    v[27] = s[1] | s[0];
    return v;
  endfunction

  function automatic logic [31:0] exp_read(logic [1:0] a);
    case (a)
      2'd0: return view(m_prim, m_sec);
      2'd1: return m_en;
      2'd2: return m_sec;
      default: return {24'd0, m_per};
    endcase
  endfunction

  task automatic chk(logic [31:0] act, logic [31:0] exp, string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(logic [31:0] pe, logic [31:0] de, logic we,
                      logic [1:0] a, logic [31:0] wd, logic tk);
    logic [31:0] v, np, ns, ne;
    logic [7:0]  nper;
    logic        rxp, nf, ni;
    int          nc;
    @(negedge clk);
    prim_evt = pe; dma_evt = de; reg_we = we; reg_addr = a;
    reg_wdata = wd; us_tick = tk;
    v   = view(m_prim, m_sec);
    rxp = v[31];
    np  = ((m_prim & ~((we && a == 2'd0) ? wd : 32'd0)) | pe) & ~SUM;
    ns  = (m_sec & ~((we && a == 2'd2) ? wd : 32'd0)) | de;
    ne  = (we && a == 2'd1) ? wd : m_en;
    nper = (we && a == 2'd3) ? wd[7:0] : m_per;
    nc = m_cnt; nf = m_fired;
    if (!rxp) begin nc = 0; nf = 1'b0; end
    else if (!m_fired && tk) begin
      if (m_cnt + 1 >= int'(m_per) * 32) begin nf = 1'b1; nc = 0; end
      else nc = m_cnt + 1;
    end
    ni = (|(v & m_en & 32'h7FFF_FFFF)) |
         (m_en[31] & (m_sec[30] | (rxp & ((m_per == 8'd0) | m_fired))));
    @(posedge clk); #1;
    m_prim = np; m_sec = ns; m_en = ne; m_per = nper;
    m_cnt = nc; m_fired = nf; m_irq = ni;
    chk({31'd0, host_irq}, {31'd0, m_irq}, "R6 R7 R8 R9 irq");
    case (a)
      2'd0: chk(reg_rdata, exp_read(a), "R2 R5 primary read");
      2'd2: chk(reg_rdata, exp_read(a), "R4 secondary read");
      default: chk(reg_rdata, exp_read(a), "R10 config read");
    endcase
  endtask

  task automatic idle(logic [1:0] a, logic tk);
    step('0, '0, 1'b0, a, '0, tk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    step('0, '0, 1'b1, a, d, 1'b0);
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      finish_up();
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      idle(2'(a), 1'b0);
      chk(reg_rdata, 32'd0, "R1 reset value");
    end
    chk({31'd0, host_irq}, 32'd0, "R1 irq low");

    // R2 set, write-0 hold, write-1 clear, summary positions ignored
    step(32'h0000_0081, '0, 1'b0, 2'd0, '0, 1'b0);
    chk(reg_rdata, 32'h0000_0081, "R2 event sets");
    wr(2'd0, 32'h0000_0000);
    chk(reg_rdata, 32'h0000_0081, "R2 write 0 holds");
    wr(2'd0, 32'h0000_0001);
    chk(reg_rdata, 32'h0000_0080, "R2 write 1 clears");
    step(SUM, '0, 1'b0, 2'd0, '0, 1'b0);
    chk(reg_rdata, 32'h0000_0080, "R2 summary positions not stored");
    wr(2'd0, 32'hFFFF_FFFF);

    // R3 set wins
    step(32'h0200_0002, '0, 1'b1, 2'd0, 32'h0200_0002, 1'b0);
    chk(reg_rdata, 32'h0200_0002, "R3 set wins on primary");
    step('0, 32'h0001_0000, 1'b1, 2'd2, 32'h0001_0000, 1'b0);
    chk(reg_rdata, 32'h0001_0000, "R3 set wins on secondary");
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd2, 32'hFFFF_FFFF);

    // R4 R5 roll-up
    step('0, 32'h8002_0002, 1'b0, 2'd0, '0, 1'b0);
    chk(reg_rdata, 32'hA800_0000, "R5 summary bits");
    idle(2'd2, 1'b0);
    chk(reg_rdata, 32'h8002_0002, "R4 secondary set");
    wr(2'd2, 32'h0002_0000);
    idle(2'd0, 1'b0);
    chk(reg_rdata, 32'h2800_0000, "R5 rx summary drops");
    wr(2'd2, 32'hFFFF_FFFF);

    // R6 enable gating and one-cycle latency
    step(32'h0000_0001, '0, 1'b0, 2'd0, '0, 1'b0);
    chk({31'd0, host_irq}, 32'd0, "R6 masked bit quiet");
    wr(2'd1, 32'h0000_0001);
    chk({31'd0, host_irq}, 32'd0, "R6 irq one cycle after mask");
    idle(2'd1, 1'b0);
    chk({31'd0, host_irq}, 32'd1, "R6 enabled bit raises");
    wr(2'd0, 32'h0000_0001);
    idle(2'd0, 1'b0);
    chk({31'd0, host_irq}, 32'd0, "R6 ack drops irq");

    // R7 coalescing window 1 unit = 32 ticks
    wr(2'd1, 32'h8000_0000);
    wr(2'd3, 32'h0000_0001);
    step('0, 32'h0002_0000, 1'b0, 2'd0, '0, 1'b1);
    for (int i = 0; i < 32; i++) idle(2'd0, 1'b1);
    chk({31'd0, host_irq}, 32'd0, "R7 quiet through window");
    idle(2'd0, 1'b1);
    chk({31'd0, host_irq}, 32'd1, "R7 raised after window");
    wr(2'd2, 32'hFFFF_FFFF);
    idle(2'd0, 1'b1);
    chk({31'd0, host_irq}, 32'd0, "R7 clears with summary");

    // R8 window zero
    wr(2'd3, 32'h0000_0000);
    step('0, 32'h0001_0000, 1'b0, 2'd0, '0, 1'b0);
    idle(2'd0, 1'b0);
    chk({31'd0, host_irq}, 32'd1, "R8 immediate without window");
    wr(2'd2, 32'hFFFF_FFFF);

    // R9 high priority bypass
    wr(2'd3, 32'h0000_00FF);
    idle(2'd3, 1'b0);
    chk(reg_rdata, 32'h0000_00FF, "R10 window readback");
    step('0, 32'h4000_0000, 1'b0, 2'd0, '0, 1'b0);
    idle(2'd0, 1'b0);
    chk({31'd0, host_irq}, 32'd1, "R9 bypasses window");
    wr(2'd2, 32'hFFFF_FFFF);

    // random mix against reference
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] pe, de, wd;
      logic        we;
      logic [1:0]  a;
      pe = ($urandom % 8 == 0) ? (32'd1 << ($urandom % 32)) : 32'd0;
      de = ($urandom % 10 == 0) ? (32'd1 << ($urandom % 32)) : 32'd0;
      if ($urandom % 12 == 0) de = de | (32'd1 << (16 + $urandom % 2));
      we = ($urandom % 6 == 0);
      a  = 2'($urandom);
      wd = $urandom;
      if (we && a == 2'd3) wd = {24'd0, 6'd0, 2'($urandom)};
      if (we && a == 2'd2 && ($urandom % 2 == 0)) wd = 32'h4000_0000;
      step(pe, de, we, a, wd, 1'($urandom));
    end
    finish_up();
  end
endmodule